// File: doc/BRIEF.md
# SPI master character transmitter

This block is the transmit side of a serial port running as an SPI master. A host writes one character at a time into a single holding register. When the shifter is free, the character moves into a shift register and goes out MSB first on the data line, with a serial clock made by a programmable divider. An active-low slave select frames every character. It falls one bit time before the first data bit and rises one bit time after the last. Between characters it stays high for at least one further bit time, so consecutive characters are always three or more bit times apart.

Two options change the framing and the pacing. A pair of control strobes can pin the slave select low across any number of characters and then let it go again, for slaves that need the select held for a whole transfer. A wait-for-read option holds each new character back while the companion receiver still reports an unread character, so the far end cannot overrun. Two status flags let the host pace its writes: holding register free, and everything written has been sent.

Top module: `spi_char_tx`

## Requirements
- R1: After reset and while `tx_en` is low, `ss_n` is 1, `sclk` is 0, `mosi` is 1, and both `tx_ready` and `tx_empty` are 0.
- R2: `tx_ready` is 1 exactly when `tx_en` is 1 and the holding register is empty. A written character leaves the holding register when it is loaded into the shift register, and `tx_ready` rises at that point.
- R3: A write (`wr_en`=1) in a cycle where `tx_ready` is 0 is discarded. The character already held is sent unchanged and the discarded one is never sent.
- R4: Data bits go out MSB first, `W` bits per character. Each bit lasts `2*(half_div+1)` clock cycles: `sclk` is 0 for the first half and 1 for the second half. `mosi` changes only while `sclk` is 0, and `sclk` is 0 outside the data bits.
- R5: When the select is not forced, `ss_n` goes to 0 exactly one bit time before the first half of the MSB. It returns to 1 exactly one bit time after the end of the LSB.
- R6: Between two characters, `ss_n` (when not forced) is 1 for at least one bit time. The gap from the end of one LSB to the start of the next MSB is at least three bit times.
- R7: A one-cycle `force_sel` pulse holds `ss_n` at 0 across characters and idle time until a `release_sel` pulse. If both pulse in the same cycle, `release_sel` wins.
- R8: With `wait_rd`=1, no character starts while `rx_ready` is 1. With `wait_rd`=0, `rx_ready` has no effect.
- R9: `tx_empty` is 1 exactly when `tx_en` is 1, the holding register is empty, and no character is in its lead, data, trail or gap time.
- R10: Dropping `tx_en` aborts any character in flight. It also empties the holding register and cancels a forced select, so on the next cycle all outputs are at their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | W | Character to send |
| force_sel | input | 1 | Strobe: pin slave select low |
| release_sel | input | 1 | Strobe: stop pinning slave select |
| wait_rd | input | 1 | 1: wait for receiver to be read before starting a character |
| rx_ready | input | 1 | Receiver holds an unread character |
| half_div | input | DIV_W | Half bit time in clock cycles, minus one |
| tx_ready | output | 1 | Holding register free |
| tx_empty | output | 1 | All written characters fully sent |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out, idle high |
| ss_n | output | 1 | Slave select, active low |

## Verification
Most wrong internal states in this block show up at the pins quickly. A mis-stepped phase counter or a wrong state shifts an `sclk` or `ss_n` edge within one half bit time. A bad shift register corrupts `mosi` at the next bit boundary. Errors in the holding register show on `tx_ready` in the very next cycle. They also show as a missing, duplicated or wrong character on the line one frame later. The bench therefore compares every output against a timing model on every clock, and rebuilds received characters from `sclk` and `mosi` to confirm the lost-write, gating and abort cases.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4
  } tx_state_t;

  // Half bit times spent in each framing phase.
  function automatic int unsigned phase_halves(tx_state_t s, int unsigned w);
    return (s == ST_SHIFT) ? 2 * w : 2;
  endfunction

  function automatic tx_state_t phase_after(tx_state_t s);
    case (s)
      ST_LEAD:  return ST_SHIFT;
      ST_SHIFT: return ST_TRAIL;
      ST_TRAIL: return ST_GAP;
      default:  return ST_IDLE;
    endcase
  endfunction

  // Clock cycles from frame start to frame end, for a given half-bit length.
  function automatic int unsigned frame_cycles(int unsigned w, int unsigned half_len);
    return (2 * w + 6) * half_len;
  endfunction

endpackage

// File: rtl/spi_tx_baud.sv
module spi_tx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R4: the half-bit counter restarts after every tick
  a_r4_tick_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);

  logic accept;
  assign accept = en && wr_en && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full <= 1'b0;
    else if (!en)    full <= 1'b0;
    else if (take)   full <= 1'b0;
    else if (accept) full <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data <= '0;
    else if (accept) data <= wr_data;
  end

  // R3: a write into an occupied holding register leaves its content alone
  a_r3_drop_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(data));

endmodule

// File: rtl/spi_tx_seq.sv
module spi_tx_seq
  import spi_tx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] load_data,
  input  logic         tick,
  output logic         idle,
  output logic         ss_act,
  output logic         sclk_o,
  output logic         mosi_o
);

  localparam int unsigned PH_W = $clog2(2 * W);

  tx_state_t     state;
  logic [PH_W-1:0] ph;
  logic [W-1:0]    shreg;
  logic            ph_last;
  logic            bit_end;

  assign ph_last = (ph == PH_W'(phase_halves(state, W) - 1));
  assign bit_end = (state == ST_SHIFT) && ph[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
      shreg <= '0;
    end else if (!en) begin
      state <= ST_IDLE;
      ph    <= '0;
    end else if (state == ST_IDLE) begin
      ph <= '0;
      if (start) begin
        shreg <= load_data;
        state <= ST_LEAD;
      end
    end else if (tick) begin
      if (ph_last) begin
        ph    <= '0;
        state <= phase_after(state);
      end else begin
        ph <= ph + 1'b1;
        if (bit_end) shreg <= {shreg[W-2:0], 1'b0};
      end
    end
  end

  assign idle   = (state == ST_IDLE);
  assign ss_act = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL);
  assign sclk_o = (state == ST_SHIFT) && ph[0];
  assign mosi_o = (state == ST_SHIFT) ? shreg[W-1] : 1'b1;

  // R4: data holds steady while the serial clock is high
  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R5: the serial clock only runs inside the select window
  a_r5_sclk_inside: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> ss_act);

endmodule

// File: rtl/spi_char_tx.sv
module spi_char_tx
  import spi_tx_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             force_sel,
  input  logic             release_sel,
  input  logic             wait_rd,
  input  logic             rx_ready,
  input  logic [DIV_W-1:0] half_div,
  output logic             tx_ready,
  output logic             tx_empty,
  output logic             sclk,
  output logic             mosi,
  output logic             ss_n
);

  logic         hold_full;
  logic [W-1:0] hold_data;
  logic         seq_idle;
  logic         seq_ss;
  logic         take;
  logic         tick;
  logic         sel_forced;

  assign take = tx_en && hold_full && seq_idle && !(wait_rd && rx_ready);

  spi_tx_hold #(.W(W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (take),
    .full      (hold_full),
    .data      (hold_data)
  );

  spi_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!seq_idle),
    .half_div (half_div),
    .tick     (tick)
  );

  spi_tx_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_en),
    .start     (take),
    .load_data (hold_data),
    .tick      (tick),
    .idle      (seq_idle),
    .ss_act    (seq_ss),
    .sclk_o    (sclk),
    .mosi_o    (mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sel_forced <= 1'b0;
    else if (!tx_en)      sel_forced <= 1'b0;
    else if (release_sel) sel_forced <= 1'b0;
    else if (force_sel)   sel_forced <= 1'b1;
  end

  assign tx_ready = tx_en && !hold_full;
  assign tx_empty = tx_en && !hold_full && seq_idle;
  assign ss_n     = !(seq_ss || sel_forced);

  // R2: leaving idle always drains the holding register
  a_r2_take_drains: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_idle) |-> !hold_full);

  // R8: a character never starts while gated by an unread receiver
  a_r8_gate_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_idle) |-> !$past(wait_rd && rx_ready));

  // R7: a force pulse on an enabled block pins the select low
  a_r7_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(force_sel) && !$past(release_sel) && $past(tx_en) && tx_en) |-> !ss_n);

  // R9: when everything is sent, the next cycle carries no serial clock
  a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |=> !sclk);

  // R10: disabled means fully quiet
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_en) && !tx_en |-> (ss_n && !sclk && mosi));

endmodule

// File: tb/spi_char_tx_test.sv
module spi_char_tx_test;

  localparam int W = 8;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, wr_en = 1'b0, force_sel = 1'b0, release_sel = 1'b0;
  logic wait_rd = 1'b0, rx_ready = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [DIV_W-1:0] half_div = 8'd1;
  logic tx_ready, tx_empty, sclk, mosi, ss_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_char_tx #(.W(W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
    .force_sel(force_sel), .release_sel(release_sel), .wait_rd(wait_rd),
    .rx_ready(rx_ready), .half_div(half_div), .tx_ready(tx_ready),
    .tx_empty(tx_empty), .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_busy, m_full, m_forced;
  int m_t, m_d;
  logic [W-1:0] m_hold, m_sh;

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_forced = 0; m_t = 0; m_d = 1;
    end else if (!tx_en) begin
      m_busy = 0; m_full = 0; m_forced = 0;
    end else begin
      acc = wr_en && !m_full;
      if (release_sel) m_forced = 0;
      else if (force_sel) m_forced = 1;
      if (m_busy) begin
        if (m_t == (2 * W + 6) * m_d - 1) m_busy = 0;
        else m_t++;
      end else if (m_full && !(wait_rd && rx_ready)) begin
        m_busy = 1; m_t = 0; m_sh = m_hold; m_full = 0; m_d = int'(half_div) + 1;
      end
      if (acc) begin m_full = 1; m_hold = wr_data; end
    end
  end

  always @(posedge clk) begin
    bit e_ss, e_sclk, e_mosi, e_rdy, e_emp;
    int bl;
    #5;
    if (rst_n && !done) begin
      bl = 2 * m_d;
      e_ss = !((m_busy && m_t < (2 * W + 4) * m_d) || m_forced);
      e_sclk = 0; e_mosi = 1;
      if (m_busy && m_t >= bl && m_t < bl + W * bl) begin
        e_sclk = (((m_t - bl) / m_d) % 2) == 1;
        e_mosi = m_sh[W - 1 - (m_t - bl) / bl];
      end
      e_rdy = tx_en && !m_full;
      e_emp = tx_en && !m_full && !m_busy;
      chk(ss_n === e_ss, "R5 ss_n", ss_n, e_ss);
      chk(sclk === e_sclk, "R4 sclk", sclk, e_sclk);
      chk(mosi === e_mosi, "R4 mosi", mosi, e_mosi);
      chk(tx_ready === e_rdy, "R2 tx_ready", tx_ready, e_rdy);
      chk(tx_empty === e_emp, "R9 tx_empty", tx_empty, e_emp);
    end
  end

  // ---------------- serial receiver for character checks ----------------
  logic [W-1:0] rx_sh;
  int rx_bits = 0;
  logic [W-1:0] rx_q[$];

  always @(posedge sclk) begin
    rx_sh = {rx_sh[W-2:0], mosi};
    rx_bits++;
    if (rx_bits == W) begin rx_q.push_back(rx_sh); rx_bits = 0; end
  end
  always @(negedge clk) if (!tx_en) rx_bits = 0;

  // ---------------- stimulus helpers ----------------
  task automatic put(input logic [W-1:0] v);
    while (!tx_ready) @(negedge clk);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_all();
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic expect_char(input logic [W-1:0] v, input string req);
    logic [W-1:0] got;
    if (rx_q.size() == 0) begin
      chk(0, req, -1, v);
    end else begin
      got = rx_q.pop_front();
      chk(got == v, req, got, v);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values while disabled
    chk(ss_n == 1, "R1 ss_n", ss_n, 1);
    chk(sclk == 0, "R1 sclk", sclk, 0);
    chk(mosi == 1, "R1 mosi", mosi, 1);
    chk(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
    chk(tx_empty == 0, "R1 tx_empty", tx_empty, 0);

    tx_en = 1;
    @(negedge clk);
    chk(tx_ready == 1, "R2 ready on enable", tx_ready, 1);
    chk(tx_empty == 1, "R9 empty on enable", tx_empty, 1);

    // R4: MSB first
    half_div = 8'd1;
    put(8'hA5);
    finish_all();
    expect_char(8'hA5, "R4 char");

    // R3: write while holding register occupied is lost
    put(8'h3C);
    chk(tx_ready == 0, "R3 not ready", tx_ready, 0);
    wr_en = 1; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 0;
    finish_all();
    repeat (4) @(negedge clk);
    expect_char(8'h3C, "R3 kept char");
    chk(rx_q.size() == 0, "R3 dropped char absent", rx_q.size(), 0);

    // R6: back-to-back characters, different dividers
    for (int dv = 0; dv < 3; dv++) begin
      int hi;
      half_div = (dv == 0) ? 8'd0 : (dv == 1) ? 8'd3 : 8'd2;
      put(8'h81 + 8'(dv));
      put(8'h5A);
      while (ss_n) @(negedge clk);
      while (!ss_n) @(negedge clk);
      hi = 0;
      while (ss_n && hi < 1000) begin hi++; @(negedge clk); end
      chk(hi >= 2 * (int'(half_div) + 1), "R6 select gap", hi, 2 * (int'(half_div) + 1));
      finish_all();
      expect_char(8'h81 + 8'(dv), "R6 first char");
      expect_char(8'h5A, "R6 second char");
    end

    // R7: forced select across characters
    half_div = 8'd1;
    pulse(force_sel);
    begin
      bit rose = 0;
      put(8'h12);
      put(8'h34);
      while (!tx_empty) begin if (ss_n) rose = 1; @(negedge clk); end
      chk(rose == 0, "R7 held low", rose, 0);
      repeat (5) @(negedge clk);
      chk(ss_n == 0, "R7 still low when idle", ss_n, 0);
    end
    pulse(release_sel);
    chk(ss_n == 1, "R7 release", ss_n, 1);
    force_sel = 1; release_sel = 1;
    @(negedge clk);
    force_sel = 0; release_sel = 0;
    chk(ss_n == 1, "R7 release wins", ss_n, 1);
    expect_char(8'h12, "R7 char a");
    expect_char(8'h34, "R7 char b");

    // R8: wait-for-read gating
    wait_rd = 1; rx_ready = 1;
    put(8'hC3);
    repeat (60) @(negedge clk);
    chk(ss_n == 1, "R8 held back ss_n", ss_n, 1);
    chk(tx_empty == 0, "R8 held back empty", tx_empty, 0);
    chk(rx_q.size() == 0, "R8 nothing sent", rx_q.size(), 0);
    rx_ready = 0;
    finish_all();
    expect_char(8'hC3, "R8 released char");
    wait_rd = 0; rx_ready = 1;
    put(8'h7E);
    finish_all();
    expect_char(8'h7E, "R8 ungated char");
    rx_ready = 0;

    // R10: abort mid-frame, forced select cancelled
    pulse(force_sel);
    put(8'hAA);
    repeat (10) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    chk(ss_n == 1, "R10 ss_n", ss_n, 1);
    chk(sclk == 0, "R10 sclk", sclk, 0);
    chk(tx_ready == 0, "R10 tx_ready", tx_ready, 0);
    chk(tx_empty == 0, "R10 tx_empty", tx_empty, 0);
    tx_en = 1;
    @(negedge clk);
    chk(tx_empty == 1, "R10 cleared on return", tx_empty, 1);
    chk(ss_n == 1, "R10 force cancelled", ss_n, 1);
    rx_q.delete();
    put(8'h69);
    finish_all();
    expect_char(8'h69, "R10 fresh char");

    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule